// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Device

This block is the device side of a small serial memory that holds 128 words of 16 bits. A host drives select (`sel`), a serial clock (`sclk`) and serial data in (`sdi`), and the block answers on `sdo`. It drives `sdo` only when `sdo_en` is high. All three host pins are brought into the system clock domain by a short synchronizer chain. Every action happens on a rising edge of `sclk` seen while `sel` is high.

A frame is a start bit, then a two-bit operation code, then an eight-bit address field, and for the two write forms 16 data bits follow. All fields are sent most significant bit first. The block supports these operations: reading with address auto-increment, single-word write, single-word erase, write-all, erase-all, and setting or clearing a write-enable latch. A modifying command starts a write timer that counts system clock cycles. While that timer runs, new frames are dropped. The storage is a register array, and an erased word reads as all ones.

The serial pins are plain signals with no valid/ready handshake. The host paces the data completely with `sclk`, and the block never pushes back.

Top module: `sm_serial_mem`

## Requirements
- R1: After `sel` rises, every `sdi` value of 0 sampled on an `sclk` rising edge is discarded, and the frame starts at the first sampled 1. While the block is hunting for this start bit, `sdo_en` stays low.
- R2: The two bits after the start bit select the operation: 10 is read, 01 is write, 11 is erase word, 00 is special. The next eight bits form the address field, a 0 and then address bits 6 down to 0. For the special operation, the top two bits of that field pick the action: 11 enables writes, 00 disables writes, 01 is write-all and 10 is erase-all.
- R3: On a read, the `sclk` rising edge that samples address bit 0 sets `sdo` to a 0 dummy bit. Each later rising edge then presents the next data bit, starting at bit 15 and ending at bit 0.
- R4: While `sclk` keeps running in a read, the words at the next addresses follow without any gap or dummy bit. The address wraps from 127 to 0.
- R5: A write stores the 16 data bits that follow the address into the addressed word.
- R6: Erase word sets the addressed word to 0xFFFF. Erase-all sets every word to 0xFFFF. Write-all stores its 16 data bits into every word.
- R7: Write, erase, write-all and erase-all change nothing unless the most recent enable or disable command was enable. Reset leaves writes disabled.
- R8: After a modifying command, every frame that starts within `WR_CYCLES` clock cycles is ignored completely, and `sdo_en` stays low for that frame.
- R9: If `sel` falls before a frame is complete, the frame is dropped and memory is not changed. The next frame is decoded normally.
- R10: `sdo_en` is high only while read data is being shifted out. It falls no more than two clock cycles after `sel` is sampled low.
- R11: After reset, every word reads 0xFFFF and `sdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Output enable for `sdo` |

## Verification
A bit counter that is off by one shows up at once. The read data comes out rotated by one place, or the dummy 0 is missing at the last address edge, so the first word read shows it. A wrong write-enable latch or a lost commit appears on the next read of the target word as a stale value or as 0xFFFF. A write timer that never expires blocks every later frame, which leaves `sdo_en` low on the following read. An address pointer that does not wrap produces the wrong second word when the read crosses from 127 to 0.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    OP_SPEC  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SUB_WDIS = 2'b00,
    SUB_WALL = 2'b01,
    SUB_EALL = 2'b10,
    SUB_WEN  = 2'b11
  } sub_e;

  typedef enum logic [2:0] {
    MC_NONE, MC_WORD, MC_ALL, MC_ERASE_WORD, MC_ERASE_ALL
  } mcmd_e;

  typedef enum logic [2:0] {
    ST_HUNT, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } st_e;
endpackage

// File: rtl/sm_pin_sync.sv
module sm_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sel_s,
  output logic sdi_s,
  output logic sk_rise
);
  logic [SYNC_STAGES-1:0] sel_p, sk_p, di_p;
  logic sk_last;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sel_p[0] <= 1'b0;
            sk_p[0]  <= 1'b0;
            di_p[0]  <= 1'b0;
          end else begin
            sel_p[0] <= sel;
            sk_p[0]  <= sclk;
            di_p[0]  <= sdi;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sel_p[g] <= 1'b0;
            sk_p[g]  <= 1'b0;
            di_p[g]  <= 1'b0;
          end else begin
            sel_p[g] <= sel_p[g-1];
            sk_p[g]  <= sk_p[g-1];
            di_p[g]  <= di_p[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_last <= 1'b0;
    else        sk_last <= sk_p[SYNC_STAGES-1];
  end

  assign sel_s   = sel_p[SYNC_STAGES-1];
  assign sdi_s   = di_p[SYNC_STAGES-1];
  assign sk_rise = sk_p[SYNC_STAGES-1] & ~sk_last;
endmodule

// File: rtl/sm_wtimer.sv
module sm_wtimer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8: a commit is only ever requested while no write cycle is running
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R8: the busy window opens only on a requested commit
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/sm_array.sv
module sm_array
  import sm_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  mcmd_e             op,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  hit;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_hit
      assign hit[g] = (waddr == ADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++) begin
        case (op)
          MC_WORD:       if (hit[i]) mem_q[i] <= wdata;
          MC_ERASE_WORD: if (hit[i]) mem_q[i] <= '1;
          MC_ALL:        mem_q[i] <= wdata;
          MC_ERASE_ALL:  mem_q[i] <= '1;
          default:       ;
        endcase
      end
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sm_cmd_decode.sv
module sm_cmd_decode
  import sm_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sdi_s,
  input  logic              sk_rise,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              mc_vld,
  output mcmd_e             mc_op,
  output logic [ADDR_W-1:0] mc_addr,
  output logic [DATA_W-1:0] mc_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int AF_W  = ADDR_W + 1;
  localparam int MAXB  = (DATA_W > AF_W) ? DATA_W : AF_W;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int RC_W  = $clog2(DATA_W);

  st_e               st;
  op_e               opc;
  logic [CNT_W-1:0]  cnt;
  logic [AF_W-1:0]   af, af_nx;
  logic [DATA_W-1:0] dsr, dsr_nx;
  logic [DATA_W-1:0] rsr;
  logic [RC_W-1:0]   rcnt;
  logic [ADDR_W-1:0] rptr;
  logic              dummy;
  logic              wen_q;
  sub_e              sub_nx;

  always_comb begin
    af_nx  = {af[AF_W-2:0], sdi_s};
    dsr_nx = {dsr[DATA_W-2:0], sdi_s};
    sub_nx = sub_e'(af_nx[AF_W-1 -: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      opc     <= OP_SPEC;
      cnt     <= '0;
      af      <= '0;
      dsr     <= '0;
      rsr     <= '0;
      rcnt    <= '0;
      rptr    <= '0;
      dummy   <= 1'b0;
      wen_q   <= 1'b0;
      mc_vld  <= 1'b0;
      mc_op   <= MC_NONE;
      mc_addr <= '0;
      mc_data <= '0;
    end else begin
      mc_vld <= 1'b0;
      if (!sel_s) begin
        st  <= ST_HUNT;
        cnt <= '0;
      end else if (sk_rise) begin
        case (st)
          ST_HUNT: begin
            if (busy)       st <= ST_DONE;
            else if (sdi_s) begin
              st  <= ST_OPC;
              cnt <= '0;
            end
          end
          ST_OPC: begin
            opc <= op_e'({opc[0], sdi_s});
            if (cnt == CNT_W'(1)) begin
              st  <= ST_ADDR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            af <= af_nx;
            if (cnt == CNT_W'(AF_W - 1)) begin
              cnt     <= '0;
              mc_addr <= af_nx[ADDR_W-1:0];
              case (opc)
                OP_READ: begin
                  st    <= ST_READ;
                  rptr  <= af_nx[ADDR_W-1:0];
                  dummy <= 1'b1;
                  rcnt  <= '0;
                end
                OP_WRITE: st <= ST_DATA;
                OP_ERASE: begin
                  st <= ST_DONE;
                  if (wen_q) begin
                    mc_vld <= 1'b1;
                    mc_op  <= MC_ERASE_WORD;
                  end
                end
                default: begin
                  case (sub_nx)
                    SUB_WEN:  begin wen_q <= 1'b1; st <= ST_DONE; end
                    SUB_WDIS: begin wen_q <= 1'b0; st <= ST_DONE; end
                    SUB_WALL: st <= ST_DATA;
                    default: begin
                      st <= ST_DONE;
                      if (wen_q) begin
                        mc_vld <= 1'b1;
                        mc_op  <= MC_ERASE_ALL;
                      end
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            dsr <= dsr_nx;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt <= '0;
              st  <= ST_DONE;
              if (wen_q) begin
                mc_vld  <= 1'b1;
                mc_op   <= (opc == OP_WRITE) ? MC_WORD : MC_ALL;
                mc_data <= dsr_nx;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (dummy || rcnt == RC_W'(DATA_W - 1)) begin
              rsr   <= rd_data;
              rptr  <= rptr + 1'b1;
              rcnt  <= '0;
              dummy <= 1'b0;
            end else begin
              rsr  <= {rsr[DATA_W-2:0], 1'b0};
              rcnt <= rcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = rptr;
  assign sdo     = (st == ST_READ && !dummy) ? rsr[DATA_W-1] : 1'b0;
  assign sdo_en  = (st == ST_READ) && sel_s;

  // R8: no memory change is requested while the write timer is running
  p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mc_vld |-> !busy);
endmodule

// File: rtl/sm_serial_mem.sv
module sm_serial_mem
  import sm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  logic              sel_s, sdi_s, sk_rise, busy, mc_vld;
  mcmd_e             mc_op;
  logic [ADDR_W-1:0] mc_addr, rd_addr;
  logic [DATA_W-1:0] mc_data, rd_data;

  sm_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .sel_s(sel_s), .sdi_s(sdi_s), .sk_rise(sk_rise)
  );

  sm_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sdi_s(sdi_s),
    .sk_rise(sk_rise), .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
    .mc_vld(mc_vld), .mc_op(mc_op), .mc_addr(mc_addr), .mc_data(mc_data),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  sm_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(mc_vld), .busy(busy)
  );

  sm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mc_vld), .op(mc_op), .waddr(mc_addr),
    .wdata(mc_data), .raddr(rd_addr), .rdata(rd_data)
  );

  // R10: output enable drops once select has been low for two samples
  generate
    if (SYNC_STAGES <= 2) begin : g_oe_chk
      p_oe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && $past(!sel)) |=> !sdo_en);
    end
  endgenerate
endmodule

// File: tb/tb_sm_serial_mem.sv
`timescale 1ns/1ps
module tb_sm_serial_mem;
  localparam int WRC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int   checks = 0, fails = 0;
  logic [15:0] rbuf [4];

  always #4 clk = ~clk;

  sm_serial_mem #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic d);
    sdi = b; sclk = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    d = sdo;
  endtask

  task automatic send(input logic [31:0] v, input int n, output logic d);
    for (int i = n - 1; i >= 0; i--) sbit(v[i], d);
  endtask

  task automatic cs_on();  sel = 1'b1; tick(3); endtask
  task automatic cs_off(); sclk = 1'b0; sel = 1'b0; tick(3); endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] v);
    logic d;
    cs_on(); send({5'b0, 1'b1, 2'b01, 1'b0, a, v}, 27, d); cs_off(); tick(WRC + 10);
  endtask

  task automatic erase_word(input logic [6:0] a);
    logic d;
    cs_on(); send({21'b0, 1'b1, 2'b11, 1'b0, a}, 11, d); cs_off(); tick(WRC + 10);
  endtask

  task automatic special(input logic [1:0] sub, input logic [15:0] v, input bit with_data);
    logic d;
    cs_on(); send({21'b0, 1'b1, 2'b00, sub, 6'b0}, 11, d);
    if (with_data) send({16'b0, v}, 16, d);
    cs_off(); tick(WRC + 10);
  endtask

  task automatic rd(input logic [6:0] a, input int n);
    logic d;
    cs_on();
    send({21'b0, 1'b1, 2'b10, 1'b0, a}, 11, d);
    chk("R3 dummy bit", {31'b0, d}, 0);
    chk("R10 oe during read", {31'b0, sdo_en}, 1);
    for (int w = 0; w < n; w++) begin
      for (int b = 0; b < 16; b++) begin
        sbit(1'b0, d);
        rbuf[w] = {rbuf[w][14:0], d};
      end
    end
    cs_off();
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", {31'b0, sdo_en}, 0);
    rd(7'd0, 1);   chk("R11 word0 erased", {16'b0, rbuf[0]}, 32'hFFFF);
    rd(7'd127, 1); chk("R11 word127 erased", {16'b0, rbuf[0]}, 32'hFFFF);
  endtask

  task automatic t_protect();
    wr(7'd3, 16'h1234);
    rd(7'd3, 1); chk("R7 write blocked after reset", {16'b0, rbuf[0]}, 32'hFFFF);
    special(2'b11, 16'h0, 1'b0);
    wr(7'd3, 16'h1234);
    rd(7'd3, 1); chk("R5 write stored", {16'b0, rbuf[0]}, 32'h1234);
    special(2'b00, 16'h0, 1'b0);
    wr(7'd3, 16'h5555);
    erase_word(7'd3);
    rd(7'd3, 1); chk("R7 disabled again", {16'b0, rbuf[0]}, 32'h1234);
    special(2'b11, 16'h0, 1'b0);
  endtask

  task automatic t_leading();
    logic d;
    cs_on();
    send(32'h0, 3, d);
    chk("R1 oe low while hunting", {31'b0, sdo_en}, 0);
    send({21'b0, 1'b1, 2'b10, 1'b0, 7'd3}, 11, d);
    chk("R1 dummy after zeros", {31'b0, d}, 0);
    for (int b = 0; b < 16; b++) begin
      sbit(1'b0, d);
      rbuf[0] = {rbuf[0][14:0], d};
    end
    cs_off();
    chk("R1 R2 read after leading zeros", {16'b0, rbuf[0]}, 32'h1234);
  endtask

  task automatic t_seq();
    wr(7'd10, 16'hA5A5); wr(7'd11, 16'h0F0F);
    rd(7'd10, 2);
    chk("R4 first word", {16'b0, rbuf[0]}, 32'hA5A5);
    chk("R4 next word", {16'b0, rbuf[1]}, 32'h0F0F);
    wr(7'd127, 16'hBEEF); wr(7'd0, 16'hCAFE);
    rd(7'd127, 2);
    chk("R4 word127", {16'b0, rbuf[0]}, 32'hBEEF);
    chk("R4 wrap to 0", {16'b0, rbuf[1]}, 32'hCAFE);
  endtask

  task automatic t_erase();
    erase_word(7'd10);
    rd(7'd10, 2);
    chk("R6 erased word", {16'b0, rbuf[0]}, 32'hFFFF);
    chk("R6 neighbour kept", {16'b0, rbuf[1]}, 32'h0F0F);
  endtask

  task automatic t_busy();
    logic d;
    cs_on(); send({5'b0, 1'b1, 2'b01, 1'b0, 7'd20, 16'h1111}, 27, d); cs_off();
    cs_on();
    send({21'b0, 1'b1, 2'b10, 1'b0, 7'd20}, 11, d);
    chk("R8 read ignored while busy", {31'b0, sdo_en}, 0);
    send(32'h0, 16, d);
    chk("R8 still ignored", {31'b0, sdo_en}, 0);
    cs_off(); tick(WRC);
    rd(7'd20, 1); chk("R8 R5 write landed", {16'b0, rbuf[0]}, 32'h1111);
  endtask

  task automatic t_abort();
    logic d;
    cs_on(); send({15'b0, 1'b1, 2'b01, 1'b0, 7'd21, 10'h3FF}, 21, d); cs_off();
    tick(WRC + 10);
    rd(7'd21, 1); chk("R9 aborted write", {16'b0, rbuf[0]}, 32'hFFFF);
  endtask

  task automatic t_oe();
    logic d;
    cs_on();
    send({21'b0, 1'b1, 2'b10, 1'b0, 7'd3}, 11, d);
    send(32'h0, 5, d);
    chk("R10 oe mid word", {31'b0, sdo_en}, 1);
    sel = 1'b0; tick(3);
    chk("R10 oe released", {31'b0, sdo_en}, 0);
    cs_off();
  endtask

  task automatic t_all();
    special(2'b01, 16'h3C3C, 1'b1);
    rd(7'd0, 1);   chk("R6 write-all word0", {16'b0, rbuf[0]}, 32'h3C3C);
    rd(7'd64, 1);  chk("R6 write-all word64", {16'b0, rbuf[0]}, 32'h3C3C);
    rd(7'd127, 1); chk("R6 write-all word127", {16'b0, rbuf[0]}, 32'h3C3C);
    special(2'b10, 16'h0, 1'b0);
    rd(7'd0, 1);   chk("R6 erase-all word0", {16'b0, rbuf[0]}, 32'hFFFF);
    rd(7'd64, 1);  chk("R6 erase-all word64", {16'b0, rbuf[0]}, 32'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(2);
    t_reset();
    t_protect();
    t_leading();
    t_seq();
    t_erase();
    t_busy();
    t_abort();
    t_oe();
    t_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule